// File: doc/BRIEF.md
# Masked Dual-Rail Precharge Logic Gate

This block is a cycle-level behavioural model of a two-input logic cell in a masked dual-rail precharge style. Every logical signal travels on a true rail and a complement rail, and both rails carry the value XOR a random mask bit. The mask itself also arrives as a rail pair. The core is a pair of 3-input majority functions. One takes the true rails of both operands together with the true mask rail. The other takes the complement rails together with the complement mask rail. When the mask is 0 the true-rail majority acts as an AND. When the mask is 1 it acts as an OR of inverted operands, which yields the masked AND result.

Operation alternates between a precharge phase and an evaluate phase. Precharge returns every rail to 0. During evaluate, a completion detector looks at the captured operand and mask pairs, and a per-lane set/reset latch records that all three pairs are complementary. The outputs stay at 0 until that latch is set. As a result, a partially arrived set of inputs cannot leak onto the outputs early. The latch is cleared by the next precharge.

A parameter selects the logic function. AND is the native core. NAND, OR and NOR reuse the same core by exchanging operand rails, output rails, or both. A lane-count parameter places independent cells side by side.

Top module: `mdrp_gate`

## Requirements
- R1: While reset is asserted, every lane's enable and both output rails read 0.
- R2: After any clock edge sampled with the precharge input high, every lane's enable, true output and complement output read 0.
- R3: Rails captured at evaluate edge k leave enable and outputs at 0 after edge k. Enable and outputs become valid only after edge k+1.
- R4: Rails are encoded as true = value XOR mask and complement = NOT true. In the AND configuration with mask 0, the true output equals a AND b.
- R5: In the AND configuration with mask 1, the true output equals NOT(a AND b), which is the masked form of the AND result.
- R6: A lane whose a, b or mask pair reads 00 or 11 never raises its enable, and both of its output rails stay 0.
- R7: Once a lane's enable is set, it stays set through later evaluate edges, even if the captured pairs become invalid, until a precharge edge.
- R8: The NAND, OR and NOR configurations give the masked true output f(a,b) XOR m for their own function f.
- R9: Each lane's enable and outputs depend only on that lane's rails. An invalid pair in one lane does not hold back another lane.
- R10: When a lane's enable is set and its captured pairs are valid, its complement output is the inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_i | input | 1 | 1 = precharge phase, 0 = evaluate phase |
| a_t_i | input | LANES | Operand a true rail, a XOR m |
| a_f_i | input | LANES | Operand a complement rail |
| b_t_i | input | LANES | Operand b true rail, b XOR m |
| b_f_i | input | LANES | Operand b complement rail |
| m_t_i | input | LANES | Mask true rail |
| m_f_i | input | LANES | Mask complement rail |
| q_t_o | output | LANES | Result true rail, q XOR m |
| q_f_o | output | LANES | Result complement rail |
| en_o | output | LANES | Per-lane completion latch state |

## Verification
The bench builds the block with four lanes and instantiates it once for each of the four function settings. All four copies see the same rail stimulus. The four lanes let one evaluate phase mix valid lanes with lanes that carry a 00 or 11 pair, which brings lane independence and the no-enable rule into a single cycle. The four function settings together exercise every combination of operand and output rail exchange around the shared majority core.

// File: rtl/mdrp_pkg.sv
package mdrp_pkg;
  typedef enum logic [1:0] {
    FN_AND  = 2'd0,
    FN_NAND = 2'd1,
    FN_OR   = 2'd2,
    FN_NOR  = 2'd3
  } gate_fn_e;
endpackage

// File: rtl/mdrp_rail_map.sv
module mdrp_rail_map #(
  parameter int unsigned LANES = 4,
  parameter bit          SWAP  = 1'b0
) (
  input  logic [LANES-1:0] x_t_i,
  input  logic [LANES-1:0] x_f_i,
  output logic [LANES-1:0] y_t_o,
  output logic [LANES-1:0] y_f_o
);
  generate
    if (SWAP) begin : g_swap
      assign y_t_o = x_f_i;
      assign y_f_o = x_t_i;
    end else begin : g_pass
      assign y_t_o = x_t_i;
      assign y_f_o = x_f_i;
    end
  endgenerate
endmodule

// File: rtl/mdrp_maj_pair.sv
module mdrp_maj_pair #(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES-1:0] a_t_i,
  input  logic [LANES-1:0] a_f_i,
  input  logic [LANES-1:0] b_t_i,
  input  logic [LANES-1:0] b_f_i,
  input  logic [LANES-1:0] m_t_i,
  input  logic [LANES-1:0] m_f_i,
  output logic [LANES-1:0] y_t_o,
  output logic [LANES-1:0] y_f_o
);
  // true-rail majority: mask 0 -> AND, mask 1 -> OR of inverted operands
  assign y_t_o = (a_t_i & b_t_i) | (a_t_i & m_t_i) | (b_t_i & m_t_i);
  // complement-rail majority on the inverse rails and inverse mask
  assign y_f_o = (a_f_i & b_f_i) | (a_f_i & m_f_i) | (b_f_i & m_f_i);
endmodule

// File: rtl/mdrp_completion.sv
module mdrp_completion #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_i,
  input  logic [LANES-1:0] a_t_i,
  input  logic [LANES-1:0] a_f_i,
  input  logic [LANES-1:0] b_t_i,
  input  logic [LANES-1:0] b_f_i,
  input  logic [LANES-1:0] m_t_i,
  input  logic [LANES-1:0] m_f_i,
  output logic [LANES-1:0] vld_o,
  output logic [LANES-1:0] en_o
);
  logic [LANES-1:0] en_q;
  logic [LANES-1:0] en_d;

  // a pair is complete only when exactly one rail is high
  assign vld_o = (a_t_i ^ a_f_i) & (b_t_i ^ b_f_i) & (m_t_i ^ m_f_i);

  // set/reset latch: set by completion, reset by precharge
  always_comb begin
    if (pre_i) en_d = '0;
    else       en_d = en_q | vld_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_idle: assert (en_q == '0);
  end

  a_r2_pre_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pre_i |=> (en_q == '0));

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
      a_r6_no_set_when_incomplete: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[i] && !vld_o[i]) |=> !en_q[i]);
      a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[i] && !pre_i) |=> en_q[i]);
    end
  endgenerate
endmodule

// File: rtl/mdrp_gate.sv
module mdrp_gate #(
  parameter int unsigned        LANES = 4,
  parameter mdrp_pkg::gate_fn_e FN    = mdrp_pkg::FN_AND
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_i,
  input  logic [LANES-1:0] a_t_i,
  input  logic [LANES-1:0] a_f_i,
  input  logic [LANES-1:0] b_t_i,
  input  logic [LANES-1:0] b_f_i,
  input  logic [LANES-1:0] m_t_i,
  input  logic [LANES-1:0] m_f_i,
  output logic [LANES-1:0] q_t_o,
  output logic [LANES-1:0] q_f_o,
  output logic [LANES-1:0] en_o
);
  import mdrp_pkg::*;

  localparam bit SWAP_IN  = (FN == FN_OR)   || (FN == FN_NOR);
  localparam bit SWAP_OUT = (FN == FN_NAND) || (FN == FN_OR);

  logic [LANES-1:0] a_t_m, a_f_m, b_t_m, b_f_m;
  logic [LANES-1:0] a_t_d, a_f_d, b_t_d, b_f_d, m_t_d, m_f_d;
  logic [LANES-1:0] a_t_q, a_f_q, b_t_q, b_f_q, m_t_q, m_f_q;
  logic [LANES-1:0] core_t, core_f, gate_t, gate_f;
  logic [LANES-1:0] en_q, vld;

  mdrp_rail_map #(.LANES(LANES), .SWAP(SWAP_IN)) u_map_a (
    .x_t_i(a_t_i), .x_f_i(a_f_i), .y_t_o(a_t_m), .y_f_o(a_f_m)
  );
  mdrp_rail_map #(.LANES(LANES), .SWAP(SWAP_IN)) u_map_b (
    .x_t_i(b_t_i), .x_f_i(b_f_i), .y_t_o(b_t_m), .y_f_o(b_f_m)
  );

  // next state: precharge returns every captured rail to 0
  always_comb begin
    if (pre_i) begin
      a_t_d = '0; a_f_d = '0; b_t_d = '0;
      b_f_d = '0; m_t_d = '0; m_f_d = '0;
    end else begin
      a_t_d = a_t_m; a_f_d = a_f_m; b_t_d = b_t_m;
      b_f_d = b_f_m; m_t_d = m_t_i; m_f_d = m_f_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_t_q <= '0; a_f_q <= '0; b_t_q <= '0;
      b_f_q <= '0; m_t_q <= '0; m_f_q <= '0;
    end else begin
      a_t_q <= a_t_d; a_f_q <= a_f_d; b_t_q <= b_t_d;
      b_f_q <= b_f_d; m_t_q <= m_t_d; m_f_q <= m_f_d;
    end
  end

  mdrp_completion #(.LANES(LANES)) u_done (
    .clk(clk), .rst_n(rst_n), .pre_i(pre_i),
    .a_t_i(a_t_q), .a_f_i(a_f_q), .b_t_i(b_t_q),
    .b_f_i(b_f_q), .m_t_i(m_t_q), .m_f_i(m_f_q),
    .vld_o(vld), .en_o(en_q)
  );

  mdrp_maj_pair #(.LANES(LANES)) u_core (
    .a_t_i(a_t_q), .a_f_i(a_f_q), .b_t_i(b_t_q),
    .b_f_i(b_f_q), .m_t_i(m_t_q), .m_f_i(m_f_q),
    .y_t_o(core_t), .y_f_o(core_f)
  );

  // evaluation reaches the rails only once the latch is set
  assign gate_t = core_t & en_q;
  assign gate_f = core_f & en_q;

  mdrp_rail_map #(.LANES(LANES), .SWAP(SWAP_OUT)) u_map_q (
    .x_t_i(gate_t), .x_f_i(gate_f), .y_t_o(q_t_o), .y_f_o(q_f_o)
  );

  assign en_o = en_q;

  a_r10_core_complementary: assert property (@(posedge clk) disable iff (!rst_n)
    (((core_t ^ core_f) & en_q & vld) == (en_q & vld)));

  a_r10_ports_complementary: assert property (@(posedge clk) disable iff (!rst_n)
    (((q_t_o ^ q_f_o) & en_q & vld) == (en_q & vld)));

  a_r2_ports_quiet_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    pre_i |=> ((q_t_o | q_f_o) == '0));
endmodule

// File: tb/mdrp_gate_bench.sv
`timescale 1ns/1ps
module mdrp_gate_bench;
  import mdrp_pkg::*;

  localparam int unsigned LANES = 4;
  localparam int unsigned NVAR  = 4;

  // {a, b, m, exp_and, exp_nand, exp_or, exp_nor}; expectations are masked true rails
  localparam logic [6:0] TBL [8] = '{
    7'b000_0101, 7'b001_1010, 7'b010_0110, 7'b011_1001,
    7'b100_0110, 7'b101_1001, 7'b110_1010, 7'b111_0101
  };

  logic clk = 1'b0;
  logic rst_n;
  logic pre;
  logic [LANES-1:0] a_t, a_f, b_t, b_f, m_t, m_f;
  logic [LANES-1:0] qt [NVAR];
  logic [LANES-1:0] qf [NVAR];
  logic [LANES-1:0] en [NVAR];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  generate
    for (genvar g = 0; g < NVAR; g++) begin : g_fn
      mdrp_gate #(.LANES(LANES), .FN(gate_fn_e'(g))) u_mdrp_gate (
        .clk(clk), .rst_n(rst_n), .pre_i(pre),
        .a_t_i(a_t), .a_f_i(a_f), .b_t_i(b_t), .b_f_i(b_f),
        .m_t_i(m_t), .m_f_i(m_f),
        .q_t_o(qt[g]), .q_f_o(qf[g]), .en_o(en[g])
      );
    end
  endgenerate

  task automatic chk(input bit ok, input string req, input logic [LANES-1:0] act,
                     input logic [LANES-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input int base, input logic [LANES-1:0] kill_b,
                       input logic [LANES-1:0] bad_m);
    for (int i = 0; i < LANES; i++) begin
      logic [6:0] e;
      e = TBL[(base + i) % 8];
      a_t[i] = e[6] ^ e[4];  a_f[i] = ~(e[6] ^ e[4]);
      b_t[i] = e[5] ^ e[4];  b_f[i] = ~(e[5] ^ e[4]);
      m_t[i] = e[4];         m_f[i] = ~e[4];
      if (kill_b[i]) begin b_t[i] = 1'b0; b_f[i] = 1'b0; end
      if (bad_m[i])  begin m_t[i] = 1'b1; m_f[i] = 1'b1; end
    end
  endtask

  function automatic logic [LANES-1:0] expect_q(input int base, input int v);
    logic [LANES-1:0] r;
    for (int i = 0; i < LANES; i++) r[i] = TBL[(base + i) % 8][3 - v];
    return r;
  endfunction

  task automatic check_zero(input string req);
    for (int v = 0; v < NVAR; v++) begin
      chk(en[v] == '0, req, en[v], '0);
      chk((qt[v] | qf[v]) == '0, req, qt[v] | qf[v], '0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pre = 1'b1;
    drive(0, '0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_zero("R1");
    rst_n = 1'b1;

    // table walk: each lane takes a different row, all four functions at once
    for (int idx = 0; idx < 8; idx++) begin
      pre = 1'b1;
      @(negedge clk);
      check_zero("R2");
      drive(idx, '0, '0);
      pre = 1'b0;
      @(negedge clk);
      check_zero("R3");
      @(negedge clk);
      for (int v = 0; v < NVAR; v++) begin
        logic [LANES-1:0] exp;
        exp = expect_q(idx, v);
        chk(en[v] == '1, "R3", en[v], '1);
        if (v == 0) begin
          for (int i = 0; i < LANES; i++) begin
            if (TBL[(idx + i) % 8][4] == 1'b0)
              chk(qt[v][i] == exp[i], "R4", qt[v], exp);
            else
              chk(qt[v][i] == exp[i], "R5", qt[v], exp);
          end
        end else begin
          chk(qt[v] == exp, "R8", qt[v], exp);
        end
        chk(qf[v] == ~qt[v], "R10", qf[v], ~qt[v]);
      end
    end

    // invalid pairs: lane 2 b pair 00, lane 3 mask pair 11
    pre = 1'b1;
    @(negedge clk);
    check_zero("R2");
    drive(3, 4'b0100, 4'b1000);
    pre = 1'b0;
    repeat (3) @(negedge clk);
    for (int v = 0; v < NVAR; v++) begin
      logic [LANES-1:0] exp;
      exp = expect_q(3, v);
      chk(en[v] == 4'b0011, "R6", en[v], 4'b0011);
      chk((qt[v][3:2] | qf[v][3:2]) == 2'b00, "R6", {qt[v][3:2], qf[v][3:2]}, '0);
      chk(qt[v][1:0] == exp[1:0], "R9", qt[v], exp);
      chk(qf[v][1:0] == ~exp[1:0], "R9", qf[v], ~exp);
    end

    // latch hold: after enable, lane 0 a pair collapses to 00
    pre = 1'b1;
    @(negedge clk);
    drive(5, '0, '0);
    pre = 1'b0;
    repeat (2) @(negedge clk);
    a_t[0] = 1'b0; a_f[0] = 1'b0;
    repeat (2) @(negedge clk);
    for (int v = 0; v < NVAR; v++) chk(en[v] == '1, "R7", en[v], '1);
    pre = 1'b1;
    @(negedge clk);
    check_zero("R2");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule